// File: doc/BRIEF.md
# Parallel-Load DAC Register Front End

This block is the digital register side of a 12-bit voltage DAC with a parallel input port. A host bus drives an active-low chip select, an active-low write enable, a register-select line and a 12-bit data word. The write is committed when write enable returns high while chip select is low. The register-select line picks the destination. When it is low, the word goes into a holding latch. When it is high, the word goes into a mode register.

A separate active-low load strobe moves the holding latch into the output code register. This gives a two-stage transfer, so a new value can be staged ahead of time and released at a chosen moment. The mode register is decoded into four flags: a speed flag, a power-down flag, an internal-reference flag and a flag for the higher internal reference level. All inputs are taken to be synchronous to `clk`.

Top module: `pdac_front`

## Requirements
- R1: After reset, `dac_code` is 0, and `fast_mode`, `power_down`, `ref_internal` and `ref_high` are all 0.
- R2: A write commits at the first rising `clk` edge at which `wr_n` is sampled high after it was sampled low at the previous edge, provided `cs_n` is low at that edge. If `reg_sel` is 0 at that edge, `din` is stored into the holding latch. `dac_code` does not change because of the write alone.
- R3: A committed write with `reg_sel` at 1 stores `din` into the mode register and leaves the holding latch unchanged.
- R4: A write whose commit edge sees `cs_n` high is ignored: neither the holding latch nor the mode flags change.
- R5: While `wr_n` stays low, changes on `din` store nothing. Only the value present at the commit edge is kept.
- R6: Each `clk` edge at which `load_n` is sampled low copies the holding latch, as it stood before that edge, into `dac_code`. While `load_n` is high, `dac_code` holds its value even when the latch is rewritten.
- R7: With `load_n` held low, `dac_code` follows every holding-latch write one clock after the commit edge.
- R8: Mode bit 0 sets speed: 0 gives slow (`fast_mode`=0) and 1 gives fast (`fast_mode`=1). The flag changes at the commit edge of the mode write.
- R9: Mode bit 1 sets power: 0 gives normal operation and 1 gives power down (`power_down`=1).
- R10: Mode bits 5:4 select the reference. 00 and 11 give external (`ref_internal`=0, `ref_high`=0). 01 gives the internal 1.024 V level (`ref_internal`=1, `ref_high`=0). 10 gives the internal 2.048 V level (`ref_internal`=1, `ref_high`=1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| wr_n | input | 1 | Write enable, active low; commits on its return high |
| reg_sel | input | 1 | 0 selects the holding latch, 1 selects the mode register |
| din | input | 12 | Parallel data word |
| load_n | input | 1 | Load strobe, active low; copies the latch to the output code |
| dac_code | output | 12 | Current code presented to the converter |
| fast_mode | output | 1 | 1 = fast settling, 0 = slow |
| power_down | output | 1 | 1 = converter powered down |
| ref_internal | output | 1 | 1 = an internal reference is selected |
| ref_high | output | 1 | 1 = the internal 2.048 V level is selected |

## Verification
The assertions assume that `cs_n`, `wr_n`, `reg_sel`, `din` and `load_n` are synchronous to `clk` and stable around each rising edge. They also assume the write-enable pulse lasts at least one full clock, so that both its low and its high level are sampled. The stimulus changes every input only on the falling edge of the clock. It holds `wr_n` low for one or more whole cycles, and it keeps `cs_n` and `reg_sel` steady through the edge at which `wr_n` is seen high again.

// File: rtl/pdac_pkg.sv
package pdac_pkg;

   // Reference selection codes carried in the two reference mode bits
   typedef enum logic [1:0] {
      REFS_EXT_A  = 2'b00,
      REFS_INT_LO = 2'b01,
      REFS_INT_HI = 2'b10,
      REFS_EXT_B  = 2'b11
   } ref_sel_e;

   // Decoded operating mode presented at the block's outputs
   typedef struct packed {
      logic fast;
      logic pwr_down;
      logic ref_int;
      logic ref_hi;
   } pdac_mode_t;

   localparam pdac_mode_t PDAC_MODE_RESET = '{fast: 1'b0, pwr_down: 1'b0,
                                              ref_int: 1'b0, ref_hi: 1'b0};

   function automatic pdac_mode_t decode_ref(input ref_sel_e sel, input pdac_mode_t m);
      pdac_mode_t r;
      r = m;
      unique case (sel)
         REFS_INT_LO: begin r.ref_int = 1'b1; r.ref_hi = 1'b0; end
         REFS_INT_HI: begin r.ref_int = 1'b1; r.ref_hi = 1'b1; end
         default:     begin r.ref_int = 1'b0; r.ref_hi = 1'b0; end
      endcase
      return r;
   endfunction

endpackage

// File: rtl/pdac_bus_if.sv
module pdac_bus_if (
   input  logic clk,
   input  logic rst_n,
   input  logic cs_n,
   input  logic wr_n,
   input  logic reg_sel,
   output logic wr_hold,
   output logic wr_ctrl
);
   logic wr_n_q;
   logic commit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) wr_n_q <= 1'b1;
      else        wr_n_q <= wr_n;
   end

   // Commit when write enable is seen high again after a low sample
   assign commit  = wr_n & ~wr_n_q & ~cs_n;
   assign wr_hold = commit & ~reg_sel;
   assign wr_ctrl = commit &  reg_sel;
endmodule

// File: rtl/pdac_regs.sv
module pdac_regs #(
   parameter int DATA_W         = 12,
   parameter int SPD_BIT        = 0,
   parameter int PWR_BIT        = 1,
   parameter int REF_LSB        = 4,
   parameter bit KEEP_ALL_CTRL  = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_hold,
   input  logic              wr_ctrl,
   input  logic [DATA_W-1:0] din,
   output logic [DATA_W-1:0] hold_q,
   output logic [DATA_W-1:0] ctrl_q
);
   localparam logic [DATA_W-1:0] ONE = {{(DATA_W-1){1'b0}}, 1'b1};
   localparam logic [DATA_W-1:0] DEF_MASK = (ONE << SPD_BIT) | (ONE << PWR_BIT)
                                          | (ONE << REF_LSB) | (ONE << (REF_LSB + 1));

   logic [DATA_W-1:0] ctrl_d;

   generate
      if (KEEP_ALL_CTRL) begin : g_full
         assign ctrl_d = din;
      end else begin : g_masked
         // Undefined bits carry no meaning, so no storage is kept for them
         assign ctrl_d = din & DEF_MASK;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       hold_q <= '0;
      else if (wr_hold) hold_q <= din;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ctrl_q <= '0;
      else if (wr_ctrl) ctrl_q <= ctrl_d;
   end
endmodule

// File: rtl/pdac_load.sv
module pdac_load #(
   parameter int DATA_W    = 12,
   parameter bit LOAD_EDGE = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_n,
   input  logic [DATA_W-1:0] hold_q,
   output logic [DATA_W-1:0] code_q
);
   logic fire;

   generate
      if (LOAD_EDGE) begin : g_edge
         logic load_n_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) load_n_q <= 1'b1;
            else        load_n_q <= load_n;
         end
         assign fire = load_n_q & ~load_n;
      end else begin : g_level
         assign fire = ~load_n;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    code_q <= '0;
      else if (fire) code_q <= hold_q;
   end
endmodule

// File: rtl/pdac_mode_dec.sv
module pdac_mode_dec
   import pdac_pkg::*;
#(
   parameter int DATA_W  = 12,
   parameter int SPD_BIT = 0,
   parameter int PWR_BIT = 1,
   parameter int REF_LSB = 4
) (
   input  logic [DATA_W-1:0] ctrl_q,
   output pdac_mode_t        mode
);
   pdac_mode_t base;
   logic       unused_ctrl;

   assign unused_ctrl = ^ctrl_q;

   always_comb begin
      base          = PDAC_MODE_RESET;
      base.fast     = ctrl_q[SPD_BIT];
      base.pwr_down = ctrl_q[PWR_BIT];
      mode          = decode_ref(ref_sel_e'(ctrl_q[REF_LSB +: 2]), base);
   end
endmodule

// File: rtl/pdac_front.sv
module pdac_front
   import pdac_pkg::*;
#(
   parameter int DATA_W        = 12,
   parameter int SPD_BIT       = 0,
   parameter int PWR_BIT       = 1,
   parameter int REF_LSB       = 4,
   parameter bit LOAD_EDGE     = 1'b0,
   parameter bit KEEP_ALL_CTRL = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n,
   input  logic              wr_n,
   input  logic              reg_sel,
   input  logic [DATA_W-1:0] din,
   input  logic              load_n,
   output logic [DATA_W-1:0] dac_code,
   output logic              fast_mode,
   output logic              power_down,
   output logic              ref_internal,
   output logic              ref_high
);
   generate
      if (REF_LSB + 1 >= DATA_W) begin : g_bad_ref
         $error("reference field does not fit the data word");
      end
      if (SPD_BIT == PWR_BIT || SPD_BIT >= DATA_W || PWR_BIT >= DATA_W) begin : g_bad_bits
         $error("speed and power bits must be distinct and inside the word");
      end
   endgenerate

   logic              wr_hold;
   logic              wr_ctrl;
   logic [DATA_W-1:0] hold_q;
   logic [DATA_W-1:0] ctrl_q;
   pdac_mode_t        mode;

   pdac_bus_if u_bus (
      .clk     (clk),
      .rst_n   (rst_n),
      .cs_n    (cs_n),
      .wr_n    (wr_n),
      .reg_sel (reg_sel),
      .wr_hold (wr_hold),
      .wr_ctrl (wr_ctrl)
   );

   pdac_regs #(
      .DATA_W(DATA_W), .SPD_BIT(SPD_BIT), .PWR_BIT(PWR_BIT),
      .REF_LSB(REF_LSB), .KEEP_ALL_CTRL(KEEP_ALL_CTRL)
   ) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_hold (wr_hold),
      .wr_ctrl (wr_ctrl),
      .din     (din),
      .hold_q  (hold_q),
      .ctrl_q  (ctrl_q)
   );

   pdac_load #(.DATA_W(DATA_W), .LOAD_EDGE(LOAD_EDGE)) u_load (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_n (load_n),
      .hold_q (hold_q),
      .code_q (dac_code)
   );

   pdac_mode_dec #(
      .DATA_W(DATA_W), .SPD_BIT(SPD_BIT), .PWR_BIT(PWR_BIT), .REF_LSB(REF_LSB)
   ) u_dec (
      .ctrl_q (ctrl_q),
      .mode   (mode)
   );

   assign fast_mode    = mode.fast;
   assign power_down   = mode.pwr_down;
   assign ref_internal = mode.ref_int;
   assign ref_high     = mode.ref_hi;
endmodule

// File: rtl/pdac_front_chk.sv
module pdac_front_chk #(
   parameter int DATA_W    = 12,
   parameter int SPD_BIT   = 0,
   parameter int PWR_BIT   = 1,
   parameter bit LOAD_EDGE = 1'b0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cs_n,
   input logic              wr_n,
   input logic              reg_sel,
   input logic [DATA_W-1:0] din,
   input logic              load_n,
   input logic [DATA_W-1:0] dac_code,
   input logic              fast_mode,
   input logic              power_down,
   input logic              ref_internal,
   input logic              ref_high,
   input logic [DATA_W-1:0] hold_q
);
   logic seen_low;
   logic wr_ev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) seen_low <= 1'b0;
      else        seen_low <= ~wr_n;
   end
   assign wr_ev = seen_low & wr_n & ~cs_n;

   // R2: latch write captures the data on the commit edge
   p_hold_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ev && !reg_sel) |=> (hold_q == $past(din)));

   // R3: mode write sets the flags and leaves the latch alone
   p_ctrl_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ev && reg_sel) |=> ($stable(hold_q) && fast_mode == $past(din[SPD_BIT])
                              && power_down == $past(din[PWR_BIT])));

   // R4, R5: no commit, no change
   p_no_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_ev |=> ($stable(hold_q) && $stable(fast_mode) && $stable(power_down)
                  && $stable(ref_internal) && $stable(ref_high)));

   // R6: strobe inactive keeps the output code
   generate
      if (LOAD_EDGE) begin : g_edge_chk
         p_load_copy_r6: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(load_n) |=> (dac_code == $past(hold_q)));
      end else begin : g_level_chk
         p_code_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
            load_n |=> $stable(dac_code));
         // R7: a held strobe tracks the latch one clock behind
         p_track_r7: assert property (@(posedge clk) disable iff (!rst_n)
            !load_n |=> (dac_code == $past(hold_q)));
      end
   endgenerate

   // R10: the high level is only ever an internal reference
   p_ref_high_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ref_high |-> ref_internal);
endmodule

bind pdac_front pdac_front_chk #(
   .DATA_W(DATA_W), .SPD_BIT(SPD_BIT), .PWR_BIT(PWR_BIT), .LOAD_EDGE(LOAD_EDGE)
) u_chk (
   .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n), .reg_sel(reg_sel),
   .din(din), .load_n(load_n), .dac_code(dac_code), .fast_mode(fast_mode),
   .power_down(power_down), .ref_internal(ref_internal), .ref_high(ref_high),
   .hold_q(hold_q)
);

// File: tb/pdac_front_test.sv
`timescale 1ns/1ps
module pdac_front_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cs_n = 1'b1;
   logic        wr_n = 1'b1;
   logic        reg_sel = 1'b0;
   logic [11:0] din = '0;
   logic        load_n = 1'b1;
   logic [11:0] dac_code;
   logic        fast_mode, power_down, ref_internal, ref_high;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   // behavioural reference state
   int m_latch = 0, m_mode = 0, m_out = 0;
   bit m_wlow = 0;

   always #2 clk = ~clk;

   pdac_front uut (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n), .reg_sel(reg_sel),
      .din(din), .load_n(load_n), .dac_code(dac_code), .fast_mode(fast_mode),
      .power_down(power_down), .ref_internal(ref_internal), .ref_high(ref_high)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   always @(posedge clk) begin
      if (!rst_n) begin
         m_latch = 0; m_mode = 0; m_out = 0; m_wlow = 0;
      end else begin
         if (!load_n) m_out = m_latch;
         if (m_wlow && wr_n && !cs_n) begin
            if (reg_sel) m_mode = din;
            else         m_latch = din;
         end
         m_wlow = !wr_n;
      end
   end

   // per-cycle comparison against the reference (R2 R6 R7 R8 R9 R10)
   always @(negedge clk) begin
      if (rst_n && !done) begin
         int rs;
         rs = (m_mode >> 4) & 3;
         chk("R6/R7 code", dac_code, m_out);
         chk("R8 speed", fast_mode, m_mode & 1);
         chk("R9 power", power_down, (m_mode >> 1) & 1);
         chk("R10 ref_int", ref_internal, (rs == 1 || rs == 2) ? 1 : 0);
         chk("R10 ref_high", ref_high, (rs == 2) ? 1 : 0);
      end
   end

   task automatic bus_wr(input bit sel_mode, input logic [11:0] d, input bit chip_on);
      @(negedge clk); cs_n = !chip_on; reg_sel = sel_mode; din = d; wr_n = 1'b0;
      @(negedge clk); wr_n = 1'b1;
      @(negedge clk); cs_n = 1'b1; din = 12'hE3C;
   endtask

   task automatic strobe();
      @(negedge clk); load_n = 1'b0;
      @(negedge clk); load_n = 1'b1;
   endtask

   initial begin
      #(4 * 100000);
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 code", dac_code, 0);
      chk("R1 flags", {fast_mode, power_down, ref_internal, ref_high}, 0);
      rst_n = 1'b1;

      bus_wr(0, 12'hABC, 1);
      chk("R2 no load yet", dac_code, 0);
      strobe();
      chk("R6 pulse copy", dac_code, 12'hABC);
      bus_wr(0, 12'h123, 1);
      chk("R6 held without strobe", dac_code, 12'hABC);
      bus_wr(0, 12'h777, 0);
      bus_wr(1, 12'h033, 0);
      chk("R4 mode unchanged", {fast_mode, power_down, ref_internal, ref_high}, 0);
      strobe();
      chk("R4 latch unchanged", dac_code, 12'h123);

      bus_wr(1, 12'h011, 1);
      chk("R8 fast", fast_mode, 1);
      chk("R10 int 1.024", {ref_internal, ref_high}, 2'b10);
      bus_wr(1, 12'h022, 1);
      chk("R9 power down", power_down, 1);
      chk("R10 int 2.048", {ref_internal, ref_high}, 2'b11);
      bus_wr(1, 12'hFF0, 1);
      chk("R10 external 11", {fast_mode, power_down, ref_internal, ref_high}, 0);
      strobe();
      chk("R3 latch untouched", dac_code, 12'h123);

      // R5: data changing while write enable stays low
      @(negedge clk); cs_n = 0; reg_sel = 0; din = 12'h111; wr_n = 0;
      @(negedge clk); din = 12'h222;
      @(negedge clk); din = 12'h5A5;
      @(negedge clk); wr_n = 1;
      @(negedge clk); cs_n = 1; din = 12'h000;
      strobe();
      chk("R5 value at release", dac_code, 12'h5A5);

      // R7: strobe held low
      @(negedge clk); load_n = 0;
      bus_wr(0, 12'h0F0, 1);
      chk("R7 one clock behind", dac_code, 12'h5A5);
      @(negedge clk);
      chk("R7 tracked", dac_code, 12'h0F0);
      for (int i = 0; i < 40; i++) bus_wr(0, 12'(i * 100), 1);
      @(negedge clk);
      chk("R7 ramp end", dac_code, 39 * 100);
      load_n = 1;
      for (int i = 0; i < 16; i++) bus_wr(i[0], 12'(i * 37 + 5), (i % 3) != 0);
      strobe();

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule